// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Waveform Output

This block is one channel that sits beside a shared free-running or periodic timer. It sees the timer's current count, a strobe that says the count has just advanced, and the pulse the counter raises when it reaches its period. Two external signals can be routed into the channel, and so can a constant low or a constant high. With the constant sources, software can trigger a capture by moving the source select from one constant to the other.

In capture mode the channel watches the routed signal for the chosen edge or edges. On each qualifying edge it stores the current count as a timestamp, raises its event flag, and marks the timestamp as unread. If a second capture arrives before the first has been read, the channel sets a sticky overflow bit. In compare mode the channel raises a match strobe on each advanced count that equals its register. The match sets the flag and samples the routed signal. A registered waveform output reacts to the match and to the period pulse according to one of eight output behaviours, which gives edge-aligned or centre-aligned PWM when the counter is set up for it.

The block has no streaming interface. A timestamp is a held register value that software fetches through the read strobe, and that strobe is the only acknowledgement the channel needs. The block never stalls, so nothing needs back-pressure. Every other pin is a plain control or status level, and all state changes on the timer clock.

Top module: `tcc_channel`

## Requirements
- R1: After reset the channel register, flag, interrupt request, overflow bit, sampled-input bit and waveform output are all 0.
- R2: `cci_o` always shows the routed source: `src_cfg` 0 selects `cap_in_a`, 1 selects `cap_in_b`, 2 selects constant 0 and 3 selects constant 1. In both-edge capture mode, moving `src_cfg` from 2 to 3 produces a capture.
- R3: With `cap_sel`=1 and synchronisation off, `edge_cfg` 0 captures nothing, 1 captures rising edges, 2 captures falling edges and 3 captures both. A qualifying edge that appears on the routed input before a clock edge loads `tmr_count` as it stands at that clock edge into `ccr_o`.
- R4: With `sync_en`=1 the routed input passes through a two-stage synchroniser. A capture therefore lands two clock edges later than with synchronisation off, and stores the count present at that later edge.
- R5: A capture sets `flag_o`. `irq_o` is high exactly when `flag_o` and `irq_en` are both high.
- R6: `cov_o` is set when a capture occurs while an earlier capture is still unread. A `rd_en` pulse in the same cycle as, or any cycle before, the new capture prevents the overflow. `cov_clr` clears the bit.
- R7: With `cap_sel`=0, `eq_o` is high in a cycle where `tmr_step`=1 and `tmr_count` equals `ccr_o`. At that clock edge `flag_o` is set and `scci_o` takes the routed input, after the synchroniser when that is enabled. `eq_o` stays low while `tmr_step`=0 and in capture mode.
- R8: `wave_o` is registered. For `out_cfg` 0 it follows `out_sw` one clock later. Otherwise it changes only on a match or a period pulse: 1 sets on match; 2 toggles on match and clears on period; 3 sets on match and clears on period; 4 toggles on match; 5 clears on match; 6 toggles on match and sets on period; 7 clears on match and sets on period.
- R9: When a match and `period_hit` coincide, the period action determines `wave_o`. Modes 1, 4 and 5 have no period action, so the match action applies.
- R10: `flag_clr` clears `flag_o`. If a capture or match occurs in the same cycle, the flag stays set.
- R11: `wr_en` loads `wr_data` into the channel register. A capture in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_count | input | 16 | Shared timer count |
| tmr_step | input | 1 | Count advanced this cycle |
| period_hit | input | 1 | Period-match pulse from the counter |
| cap_in_a | input | 1 | External capture source A |
| cap_in_b | input | 1 | External capture source B |
| cap_sel | input | 1 | 1 = capture mode, 0 = compare mode |
| edge_cfg | input | 2 | Capture edge selection |
| src_cfg | input | 2 | Input source selection |
| sync_en | input | 1 | Synchronise routed input |
| out_cfg | input | 3 | Waveform output behaviour |
| out_sw | input | 1 | Software level for output behaviour 0 |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Channel register write strobe |
| wr_data | input | 16 | Channel register write data |
| rd_en | input | 1 | Channel register read strobe |
| flag_clr | input | 1 | Clear event flag |
| cov_clr | input | 1 | Clear overflow bit |
| ccr_o | output | 16 | Channel register value |
| flag_o | output | 1 | Event flag |
| irq_o | output | 1 | Interrupt request |
| cov_o | output | 1 | Capture overflow |
| cci_o | output | 1 | Routed input, live |
| scci_o | output | 1 | Input sampled at last match |
| eq_o | output | 1 | Compare match strobe |
| wave_o | output | 1 | Waveform output |

## Verification
The bench aims at the cases where the timing or the precedence is easy to get wrong, and each has a visible symptom:
- **Synchroniser latency:** an off-by-one pipeline stores the count from a neighbouring cycle.
- **Edge selection:** a swapped edge decode captures on the wrong transition.
- **Read racing a capture:** mishandling a read in the same cycle as a capture either raises a false overflow or misses a real one.
- **Stalled count:** a channel that ignores `tmr_step` matches repeatedly while the count holds.
- **Output behaviours under random periods and compare values:** the bench includes cycles where the match and the period pulse coincide. A design that lets the match win there, or that mixes up set, clear and toggle, diverges from the bench's output model.
- **Flag clear racing a new event:** a design that lets the clear win loses an event.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [2:0] {
    OM_SW      = 3'd0,
    OM_SET     = 3'd1,
    OM_TOG_CLR = 3'd2,
    OM_SET_CLR = 3'd3,
    OM_TOG     = 3'd4,
    OM_CLR     = 3'd5,
    OM_TOG_SET = 3'd6,
    OM_CLR_SET = 3'd7
  } out_mode_e;

  typedef enum logic [1:0] {
    CE_NONE = 2'd0,
    CE_RISE = 2'd1,
    CE_FALL = 2'd2,
    CE_BOTH = 2'd3
  } cap_edge_e;

  typedef enum logic [1:0] {
    SRC_A    = 2'd0,
    SRC_B    = 2'd1,
    SRC_LOW  = 2'd2,
    SRC_HIGH = 2'd3
  } src_sel_e;
endpackage

// File: rtl/tcc_insel.sv
module tcc_insel
  import tcc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_a,
  input  logic     in_b,
  input  src_sel_e src,
  input  logic     sync_en,
  output logic     raw_o,
  output logic     sig_o,
  output logic     rise_o,
  output logic     fall_o
);
  logic raw;
  logic synced;
  logic prev;

  always_comb begin
    case (src)
      SRC_A:    raw = in_a;
      SRC_B:    raw = in_b;
      SRC_LOW:  raw = 1'b0;
      default:  raw = 1'b1;
    endcase
  end

  generate
    if (SYNC_STAGES < 2) begin : g_single
      logic stage;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= 1'b0;
        else        stage <= raw;
      end
      assign synced = stage;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], raw};
      end
      assign synced = chain[SYNC_STAGES-1];
    end
  endgenerate

  assign sig_o = sync_en ? synced : raw;
  assign raw_o = raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sig_o;
  end

  assign rise_o = sig_o & ~prev;
  assign fall_o = ~sig_o & prev;
endmodule

// File: rtl/tcc_capcmp.sv
module tcc_capcmp
  import tcc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          step,
  input  logic          cap_sel,
  input  cap_edge_e     edge_mode,
  input  logic          rise,
  input  logic          fall,
  input  logic          sig,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          flag_clr,
  input  logic          cov_clr,
  input  logic          irq_en,
  output logic [CW-1:0] ccr_o,
  output logic          flag_o,
  output logic          irq_o,
  output logic          cov_o,
  output logic          scci_o,
  output logic          eq_o
);
  logic edge_hit;
  logic cap_evt;
  logic unread;

  always_comb begin
    case (edge_mode)
      CE_RISE: edge_hit = rise;
      CE_FALL: edge_hit = fall;
      CE_BOTH: edge_hit = rise | fall;
      default: edge_hit = 1'b0;
    endcase
  end

  assign cap_evt = cap_sel & edge_hit;
  assign eq_o    = ~cap_sel & step & (count == ccr_o);

  // capture has priority over a software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ccr_o <= '0;
    else if (cap_evt) ccr_o <= count;
    else if (wr_en)   ccr_o <= wr_data;
  end

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               flag_o <= 1'b0;
    else if (cap_evt || eq_o) flag_o <= 1'b1;
    else if (flag_clr)        flag_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       unread <= 1'b0;
    else if (cap_evt) unread <= 1'b1;
    else if (rd_en)   unread <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cov_o <= 1'b0;
    else if (cap_evt && unread && !rd_en) cov_o <= 1'b1;
    else if (cov_clr)                    cov_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    scci_o <= 1'b0;
    else if (eq_o) scci_o <= sig;
  end

  assign irq_o = flag_o & irq_en;
endmodule

// File: rtl/tcc_outunit.sv
module tcc_outunit
  import tcc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  out_mode_e mode,
  input  logic      out_sw,
  input  logic      eq,
  input  logic      period_hit,
  output logic      wave_o
);
  logic nxt;

  // match action first, period action afterwards so it overrides
  always_comb begin
    nxt = wave_o;
    case (mode)
      OM_SW: nxt = out_sw;
      OM_SET: if (eq) nxt = 1'b1;
      OM_TOG_CLR: begin
        if (eq)         nxt = ~wave_o;
        if (period_hit) nxt = 1'b0;
      end
      OM_SET_CLR: begin
        if (eq)         nxt = 1'b1;
        if (period_hit) nxt = 1'b0;
      end
      OM_TOG: if (eq) nxt = ~wave_o;
      OM_CLR: if (eq) nxt = 1'b0;
      OM_TOG_SET: begin
        if (eq)         nxt = ~wave_o;
        if (period_hit) nxt = 1'b1;
      end
      default: begin
        if (eq)         nxt = 1'b0;
        if (period_hit) nxt = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_o <= 1'b0;
    else        wave_o <= nxt;
  end
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
  import tcc_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tmr_count,
  input  logic          tmr_step,
  input  logic          period_hit,
  input  logic          cap_in_a,
  input  logic          cap_in_b,
  input  logic          cap_sel,
  input  logic [1:0]    edge_cfg,
  input  logic [1:0]    src_cfg,
  input  logic          sync_en,
  input  logic [2:0]    out_cfg,
  input  logic          out_sw,
  input  logic          irq_en,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          flag_clr,
  input  logic          cov_clr,
  output logic [CW-1:0] ccr_o,
  output logic          flag_o,
  output logic          irq_o,
  output logic          cov_o,
  output logic          cci_o,
  output logic          scci_o,
  output logic          eq_o,
  output logic          wave_o
);
  logic sig, rise, fall;

  tcc_insel #(.SYNC_STAGES(SYNC_STAGES)) u_insel (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_a    (cap_in_a),
    .in_b    (cap_in_b),
    .src     (src_sel_e'(src_cfg)),
    .sync_en (sync_en),
    .raw_o   (cci_o),
    .sig_o   (sig),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  tcc_capcmp #(.CW(CW)) u_capcmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (tmr_count),
    .step      (tmr_step),
    .cap_sel   (cap_sel),
    .edge_mode (cap_edge_e'(edge_cfg)),
    .rise      (rise),
    .fall      (fall),
    .sig       (sig),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .flag_clr  (flag_clr),
    .cov_clr   (cov_clr),
    .irq_en    (irq_en),
    .ccr_o     (ccr_o),
    .flag_o    (flag_o),
    .irq_o     (irq_o),
    .cov_o     (cov_o),
    .scci_o    (scci_o),
    .eq_o      (eq_o)
  );

  tcc_outunit u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (out_mode_e'(out_cfg)),
    .out_sw     (out_sw),
    .eq         (eq_o),
    .period_hit (period_hit),
    .wave_o     (wave_o)
  );
endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tmr_step,
  input logic          period_hit,
  input logic          cap_sel,
  input logic          sync_en,
  input logic [2:0]    out_cfg,
  input logic          out_sw,
  input logic          wr_en,
  input logic [CW-1:0] wr_data,
  input logic          rd_en,
  input logic [CW-1:0] ccr_o,
  input logic          flag_o,
  input logic          cov_o,
  input logic          cci_o,
  input logic          scci_o,
  input logic          eq_o,
  input logic          wave_o
);
  assert_match_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eq_o |=> flag_o);

  assert_no_match_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_sel || !tmr_step) |-> !eq_o);

  assert_match_samples_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_o && !sync_en) |=> (scci_o == $past(cci_o)));

  assert_sw_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cfg == 3'd0) |=> (wave_o == $past(out_sw)));

  assert_wave_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cfg != 3'd0 && !eq_o && !period_hit) |=> $stable(wave_o));

  assert_period_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (period_hit && out_cfg == 3'd3) |=> !wave_o);

  assert_period_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (period_hit && out_cfg == 3'd7) |=> wave_o);

  assert_no_overflow_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cov_o) |-> !$past(rd_en));

  assert_write_loads_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cap_sel) |=> (ccr_o == $past(wr_data)));
endmodule

bind tcc_channel tcc_channel_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tmr_step   (tmr_step),
  .period_hit (period_hit),
  .cap_sel    (cap_sel),
  .sync_en    (sync_en),
  .out_cfg    (out_cfg),
  .out_sw     (out_sw),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .ccr_o      (ccr_o),
  .flag_o     (flag_o),
  .cov_o      (cov_o),
  .cci_o      (cci_o),
  .scci_o     (scci_o),
  .eq_o       (eq_o),
  .wave_o     (wave_o)
);

// File: tb/tcc_channel_tb.sv
module tcc_channel_tb;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] tmr_count = '0;
  logic          tmr_step = 1'b0, period_hit = 1'b0;
  logic          cap_in_a = 1'b0, cap_in_b = 1'b0, cap_sel = 1'b0;
  logic [1:0]    edge_cfg = 2'd0, src_cfg = 2'd0;
  logic          sync_en = 1'b0;
  logic [2:0]    out_cfg = 3'd0;
  logic          out_sw = 1'b0, irq_en = 1'b0, wr_en = 1'b0;
  logic [CW-1:0] wr_data = '0;
  logic          rd_en = 1'b0, flag_clr = 1'b0, cov_clr = 1'b0;
  logic [CW-1:0] ccr_o;
  logic          flag_o, irq_o, cov_o, cci_o, scci_o, eq_o, wave_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tcc_channel #(.CW(CW), .SYNC_STAGES(2)) u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic wave_next(logic [2:0] m, logic cur, logic sw, logic mt, logic pe);
    logic n;
    n = cur;
    case (m)
      3'd0: n = sw;
      3'd1: if (mt) n = 1'b1;
      3'd2: begin if (mt) n = ~cur; if (pe) n = 1'b0; end
      3'd3: begin if (mt) n = 1'b1; if (pe) n = 1'b0; end
      3'd4: if (mt) n = ~cur;
      3'd5: if (mt) n = 1'b0;
      3'd6: begin if (mt) n = ~cur; if (pe) n = 1'b1; end
      default: begin if (mt) n = 1'b0; if (pe) n = 1'b1; end
    endcase
    return n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 ccr", ccr_o, 0);
    chk("R1 flag", flag_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 cov", cov_o, 0);
    chk("R1 scci", scci_o, 0);
    chk("R1 wave", wave_o, 0);
    rst_n = 1'b1;
    cyc();

    // R2 source routing
    for (int i = 0; i < 16; i++) begin
      logic a, b, e;
      a = i[0]; b = i[1];
      cap_in_a = a; cap_in_b = b; src_cfg = i[3:2];
      #1;
      case (i[3:2])
        2'd0: e = a;
        2'd1: e = b;
        2'd2: e = 1'b0;
        default: e = 1'b1;
      endcase
      chk("R2 cci", cci_o, e);
    end
    cap_in_a = 0; cap_in_b = 0; src_cfg = 2'd0;
    cap_sel = 1; edge_cfg = 2'd1;
    cyc(); cyc();
    flag_clr = 1; cyc(); flag_clr = 0;

    // R3 rising capture, R5 flag/irq
    tmr_count = 100; cap_in_a = 1; cyc();
    chk("R3 rise capture", ccr_o, 100);
    chk("R5 flag", flag_o, 1);
    chk("R5 irq off", irq_o, 0);
    irq_en = 1; #1;
    chk("R5 irq on", irq_o, 1);
    flag_clr = 1; rd_en = 1; cyc(); flag_clr = 0; rd_en = 0;
    chk("R10 flag cleared", flag_o, 0);
    tmr_count = 110; cap_in_a = 0; cyc();
    chk("R3 fall ignored in rise mode", ccr_o, 100);
    chk("R3 no flag", flag_o, 0);
    edge_cfg = 2'd2;
    tmr_count = 120; cap_in_a = 1; cyc();
    chk("R3 rise ignored in fall mode", ccr_o, 100);
    tmr_count = 130; cap_in_a = 0; cyc();
    chk("R3 fall capture", ccr_o, 130);
    edge_cfg = 2'd0;
    tmr_count = 140; cap_in_a = 1; cyc();
    chk("R3 none mode", ccr_o, 130);
    edge_cfg = 2'd3;
    tmr_count = 150; cap_in_a = 0; cyc();
    chk("R3 both fall", ccr_o, 150);
    chk("R6 overflow set", cov_o, 1);
    cov_clr = 1; rd_en = 1; cyc(); cov_clr = 0; rd_en = 0;
    chk("R6 overflow cleared", cov_o, 0);
    tmr_count = 160; cap_in_a = 1; cyc();
    chk("R3 both rise", ccr_o, 160);
    chk("R6 no overflow after read", cov_o, 0);
    tmr_count = 170; cap_in_a = 0; rd_en = 1; cyc(); rd_en = 0;
    chk("R6 same-cycle read", cov_o, 0);
    chk("R6 capture 170", ccr_o, 170);
    // R2 software capture via constant sources
    src_cfg = 2'd2; cyc();
    tmr_count = 180; src_cfg = 2'd3; cyc();
    chk("R2 software capture", ccr_o, 180);
    rd_en = 1; cyc(); rd_en = 0;

    // R4 synchronised capture
    src_cfg = 2'd0; edge_cfg = 2'd1; sync_en = 1; cap_in_a = 0;
    cyc(); cyc(); cyc();
    tmr_count = 200; cap_in_a = 1; cyc();
    tmr_count = 201; cyc();
    chk("R4 not yet captured", ccr_o, 180);
    tmr_count = 202; cyc();
    chk("R4 sync capture", ccr_o, 202);
    sync_en = 0; rd_en = 1; cyc(); rd_en = 0;

    // R11 write, and capture winning over write
    cap_sel = 0; wr_en = 1; wr_data = 16'h1234; cyc(); wr_en = 0;
    chk("R11 write", ccr_o, 16'h1234);
    cap_sel = 1; edge_cfg = 2'd3; cap_in_a = 1; cyc();
    tmr_count = 300; cap_in_a = 0; wr_en = 1; wr_data = 16'h5555; cyc(); wr_en = 0;
    chk("R11 capture beats write", ccr_o, 300);
    rd_en = 1; cyc(); rd_en = 0;

    // R7 compare
    cap_sel = 0; wr_en = 1; wr_data = 50; cyc(); wr_en = 0;
    flag_clr = 1; cyc(); flag_clr = 0;
    tmr_count = 50; tmr_step = 0; #1;
    chk("R7 no match while stalled", eq_o, 0);
    cyc();
    chk("R7 no flag while stalled", flag_o, 0);
    cap_in_a = 1; tmr_step = 1; #1;
    chk("R7 match strobe", eq_o, 1);
    cyc();
    chk("R7 match flag", flag_o, 1);
    chk("R7 scci high", scci_o, 1);
    cap_in_a = 0; flag_clr = 1; cyc(); flag_clr = 0;
    chk("R10 set beats clear", flag_o, 1);
    chk("R7 scci low", scci_o, 0);
    cap_sel = 1; #1;
    chk("R7 no match in capture mode", eq_o, 0);
    cap_sel = 0; tmr_count = 51; flag_clr = 1; cyc(); flag_clr = 0;
    chk("R10 clear", flag_o, 0);

    // R9 directed coincidence
    out_cfg = 3'd0; out_sw = 0; tmr_count = 51; cyc();
    out_cfg = 3'd7; tmr_count = 50; period_hit = 1; cyc();
    chk("R9 mode7 period wins", wave_o, 1);
    out_cfg = 3'd3; cyc();
    chk("R9 mode3 period wins", wave_o, 0);
    out_cfg = 3'd1; cyc();
    chk("R9 mode1 match applies", wave_o, 1);
    period_hit = 0;

    // R8 random output behaviour against model
    for (int m = 0; m < 8; m++) begin
      for (int rep = 0; rep < 4; rep++) begin
        int per;
        logic expw;
        per = 5 + int'($urandom_range(15));
        out_cfg = 3'd0; out_sw = 0; tmr_step = 0; period_hit = 0; cyc();
        expw = 1'b0;
        chk("R8 sw zero", wave_o, 0);
        wr_en = 1; wr_data = CW'($urandom_range(per)); cyc(); wr_en = 0;
        out_cfg = 3'(m);
        tmr_count = 0;
        for (int c = 0; c < 4 * per; c++) begin
          logic mt;
          tmr_step = ($urandom_range(7) != 0);
          period_hit = tmr_step && (tmr_count == CW'(per));
          out_sw = $urandom_range(1);
          mt = tmr_step && (tmr_count == wr_data);
          #1;
          chk("R7 match strobe model", eq_o, mt);
          expw = wave_next(3'(m), expw, out_sw, mt, period_hit);
          cyc();
          chk((m == 0) ? "R8 sw level" : "R8 R9 wave model", wave_o, expw);
          if (tmr_step) tmr_count = (tmr_count == CW'(per)) ? '0 : tmr_count + 1'b1;
        end
        tmr_step = 0; period_hit = 0;
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule